// File: doc/BRIEF.md
# Paged Byte-Write Load Controller

This block is the write side of a parallel nonvolatile memory that fills a page buffer before it programs. A system clock samples the active-low chip enable, write enable and output enable pins, the address bus and the data bus. Each write strobe places one byte in a page buffer, and a per-byte mask records which positions were filled. The host paces the load. When no byte has been accepted for a set number of clock cycles, the block enters a self-timed programming phase. In that phase it copies only the filled positions into the backing array and then returns to idle.

Inside the block, the strobe decoder hands each captured byte to the page controller as a valid/ready transfer. Valid is a one-cycle pulse. Ready is low for the whole programming phase. The pins cannot be held off, so a byte offered while ready is low is discarded, and the host must watch `busy` or poll with reads. Reads drive the array contents. During programming they return a status byte instead. The address width is a parameter with a default of 11 bits for simulation, and the full part uses 15. The offset field is always the low 6 bits. `PROG_CYC` must be at least the page size of 64.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `busy` is low, `dout_oe` is low and `dout` is zero.
- R2: A write strobe is the interval where both `ce_n` and `we_n` are low. The address is captured when the later of the two falls. The data is the value on `din` on the last clock of the strobe, before the first of the two rises. Address changes later in the strobe have no effect.
- R3: Address bits [ADDR_W-1:6] select the page and bits [5:0] select the byte within it. While a page is loading, a strobe that names a different page is discarded, and the page it names is left unchanged.
- R4: Bytes of a page may be loaded in any order. A position loaded twice in one load period keeps the last value.
- R5: Programming writes only the positions loaded in the current load period. Every other byte of the page keeps its earlier content.
- R6: Programming starts `LOAD_WIN` cycles after the last accepted byte. Every accepted byte restarts that count.
- R7: `busy` stays high for exactly `PROG_CYC` clock cycles. After it falls, reads return the programmed data.
- R8: Strobes that complete while `busy` is high are discarded. They change no array byte, do not alter the status byte, and do not start a new load.
- R9: When `ce_n` and `oe_n` are low and `we_n` is high, `dout_oe` goes high one clock later and `dout` carries the addressed byte. Otherwise `dout_oe` is low and `dout` is zero.
- R10: A read while `busy` is high returns a status byte. Bit 7 is the inverse of bit 7 of the last accepted byte. Bit 6 flips at the start of each new read. Bits 5:0 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; the low 6 bits are the page offset |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte, zero when not driven |
| dout_oe | output | 1 | High when `dout` is driven onto the bus |
| busy | output | 1 | High during the programming phase |

## Verification
Several load patterns are used, and each one isolates a different way the page buffer could fail:
- A full page loaded in descending offset order shows that position is taken from the address and not from the arrival order.
- A repeated offset shows that a later value replaces an earlier one.
- A two-byte reload of a page that is already full separates masked commits from whole-page rewrites.
- A strobe to a foreign page and strobes during programming show that discards leave the array untouched.
- A strobe whose address moves mid-pulse and whose data changes twice shows the capture point of each.
- Two bytes spaced just under the window apart show that the timer restarts.
- Back-to-back reads during programming show the status byte alternating.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } ctl_st_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/eep_strobe.sv
module eep_strobe #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              byte_vld,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [DATA_W-1:0] byte_data,
  output logic              rd_now
);
  logic wr_now, wr_q;

  assign wr_now = !ce_n && !we_n;
  assign rd_now = !ce_n && !oe_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      byte_vld  <= 1'b0;
      byte_addr <= '0;
      byte_data <= '0;
    end else begin
      wr_q     <= wr_now;
      byte_vld <= wr_q && !wr_now;
      if (wr_now && !wr_q) byte_addr <= addr;
      if (wr_now)          byte_data <= din;
    end
  end

  // R2: each strobe yields exactly one single-cycle byte transfer
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
endmodule

// File: rtl/eep_page.sv
module eep_page
  import eep_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int OFF_W    = 6,
  parameter int LOAD_WIN = 40,
  parameter int PROG_CYC = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [DATA_W-1:0] byte_data,
  output logic              busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] last_data
);
  localparam int PAGE_N = 1 << OFF_W;
  localparam int PG_W   = ADDR_W - OFF_W;
  localparam int CNT_W  = $clog2(max2(max2(LOAD_WIN, PROG_CYC), PAGE_N) + 1);
  localparam logic [CNT_W-1:0] WIN_END = CNT_W'(LOAD_WIN - 1);
  localparam logic [CNT_W-1:0] PRG_END = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] SCAN_N  = CNT_W'(PAGE_N);

  ctl_st_e             st;
  logic [PG_W-1:0]     pg;
  logic [PAGE_N-1:0]   mask;
  logic [CNT_W-1:0]    cnt;
  logic [DATA_W-1:0]   pbuf [PAGE_N];

  logic                byte_rdy, take, hit, scan_on;
  logic [OFF_W-1:0]    off, scan;
  logic [PG_W-1:0]     bpg;

  assign off      = byte_addr[OFF_W-1:0];
  assign bpg      = byte_addr[ADDR_W-1:OFF_W];
  assign byte_rdy = (st != ST_PROG);
  assign take     = byte_vld && byte_rdy;
  assign hit      = take && ((st == ST_IDLE) || (bpg == pg));
  assign busy     = (st == ST_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pg        <= '0;
      mask      <= '0;
      cnt       <= '0;
      last_data <= '0;
    end else begin
      if (hit) begin
        mask[off] <= 1'b1;
        last_data <= byte_data;
      end
      unique case (st)
        ST_IDLE: begin
          if (hit) begin
            pg  <= bpg;
            cnt <= '0;
            st  <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (hit)                 cnt <= '0;
          else if (cnt == WIN_END) begin
            cnt <= '0;
            st  <= ST_PROG;
          end else                 cnt <= cnt + 1'b1;
        end
        ST_PROG: begin
          if (cnt == PRG_END) begin
            cnt  <= '0;
            mask <= '0;
            st   <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (hit && (off == OFF_W'(g))) pbuf[g] <= byte_data;
    end
  end

  assign scan_on = busy && (cnt < SCAN_N);
  assign scan    = cnt[OFF_W-1:0];
  assign wr_en   = scan_on && mask[scan];
  assign wr_addr = {pg, scan};
  assign wr_data = pbuf[scan];

  // R8: a byte offered during programming leaves the status source alone
  a_r8_drop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && byte_vld) |=> $stable(last_data));
  // R6: an accepted byte never lets the window expire on the next edge
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !busy) |=> !busy);
  // R5: programming only ever runs with at least one loaded position
  a_r5_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mask != '0));
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_now,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              busy,
  input  logic [DATA_W-1:0] last_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              rd_q, tgl, rise;
  logic [DATA_W-1:0] status;

  assign rise = rd_now && !rd_q;

  always_comb begin
    status             = '0;
    status[DATA_W-1]   = ~last_data[DATA_W-1];
    status[DATA_W-2]   = tgl ^ rise;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      tgl     <= 1'b0;
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      rd_q    <= rd_now;
      dout_oe <= rd_now;
      if (rise && busy) tgl <= ~tgl;
      if (!rd_now)   dout <= '0;
      else if (busy) dout <= status;
      else           dout <= mem[rd_addr];
    end
  end

  // R7: the array is only written inside the programming phase
  a_r7_write_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W   = 11,
  parameter int LOAD_WIN = 40,
  parameter int PROG_CYC = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_oe,
  output logic              busy
);
  localparam int DATA_W = 8;
  localparam int OFF_W  = 6;

  logic              byte_vld, rd_now, wr_en;
  logic [ADDR_W-1:0] byte_addr, wr_addr;
  logic [DATA_W-1:0] byte_data, wr_data, last_data;

  eep_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .byte_vld(byte_vld), .byte_addr(byte_addr),
    .byte_data(byte_data), .rd_now(rd_now)
  );

  eep_page #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W),
    .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)
  ) u_page (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_addr(byte_addr),
    .byte_data(byte_data), .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .last_data(last_data)
  );

  eep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_now(rd_now), .rd_addr(addr), .busy(busy),
    .last_data(last_data), .dout(dout), .dout_oe(dout_oe)
  );
endmodule

// File: tb/eeprom_page_writer_test.sv
`timescale 1ns/1ps
module eeprom_page_writer_test;
  localparam int AW = 11;
  localparam int LW = 40;
  localparam int PC = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr_p = '0;
  logic [7:0] din_p = '0;
  logic [7:0] dout;
  logic dout_oe, busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] ref_mem [1 << AW];
  logic [7:0] pd [64];
  logic [63:0] pm = '0;
  int pp = 0;

  int exp_q[$];
  string tag_q[$];
  event smp_ev;

  always #2.5 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(AW), .LOAD_WIN(LW), .PROG_CYC(PC)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr_p), .din(din_p), .dout(dout), .dout_oe(dout_oe), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data as results are sampled
  always begin
    @(smp_ev);
    if (exp_q.size() > 0) begin
      automatic int e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(dout_oe === 1'b1, {t, " oe"}, int'(dout_oe), 1);
      chk(dout === 8'(e), t, int'(dout), e);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr_p = AW'(a); din_p = 8'(d); ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ld(input int p, input int o, input int d);
    if (pm == '0) pp = p;
    pd[o] = 8'(d); pm[o] = 1'b1;
    wr(p * 64 + o, d);
  endtask

  task automatic apply_pend();
    for (int o = 0; o < 64; o++) if (pm[o]) ref_mem[pp * 64 + o] = pd[o];
    pm = '0;
  endtask

  task automatic commit(input string tag);
    int t = 0;
    int n = 0;
    while (!busy && t < 400) begin @(negedge clk); t++; end
    chk(busy === 1'b1, {tag, " R6 programming start"}, int'(busy), 1);
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == PC, "R7 busy length", n, PC);
    apply_pend();
  endtask

  task automatic rd(input int a, input int e, input string req);
    @(negedge clk);
    addr_p = AW'(a); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk); @(negedge clk);
    -> smp_ev;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_ref(input int p, input int o, input string req);
    rd(p * 64 + o, int'(ref_mem[p * 64 + o]), req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1 busy", int'(busy), 0);
    chk(dout_oe === 1'b0, "R1 dout_oe", int'(dout_oe), 0);
    chk(dout === 8'h00, "R1 dout", int'(dout), 0);

    // R4 full page loaded in descending order
    for (int o = 63; o >= 0; o--) ld(3, o, (o * 7 + 3) & 8'hFF);
    commit("full");
    for (int o = 0; o < 64; o++) rd_ref(3, o, "R4 reverse order");

    // R9 no drive when output enable high
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(dout_oe === 1'b0, "R9 oe high", int'(dout_oe), 0);
    chk(dout === 8'h00, "R9 dout quiet", int'(dout), 0);
    ce_n = 1'b1;
    @(negedge clk);

    // R4 overwrite within a load period
    ld(5, 10, 8'h11); ld(5, 3, 8'h33); ld(5, 10, 8'h22);
    commit("overwrite");
    rd(5 * 64 + 10, 8'h22, "R4 overwrite");
    rd(5 * 64 + 3, 8'h33, "R4 second byte");

    // R5 partial reload of page 3
    ld(3, 62, 8'hC6); ld(3, 1, 8'hE1);
    commit("partial");
    for (int o = 0; o < 64; o++) rd_ref(3, o, "R5 partial page");

    // prefill for later cases
    ld(8, 0, 8'h01); commit("pre8");
    ld(11, 0, 8'h02); commit("pre11");
    ld(12, 7, 8'h03); ld(12, 8, 8'h04); commit("pre12");

    // R3 foreign page strobe dropped
    ld(7, 0, 8'hA5);
    wr(8 * 64, 8'h5A);
    commit("foreign");
    rd(7 * 64, 8'hA5, "R3 own page");
    rd(8 * 64, 8'h01, "R3 foreign page untouched");

    // R6 window restart
    begin
      int t = 0;
      ld(9, 0, 8'h91);
      repeat (LW - 8) @(negedge clk);
      chk(busy === 1'b0, "R6 before window", int'(busy), 0);
      ld(9, 1, 8'h92);
      repeat (LW - 8) @(negedge clk);
      chk(busy === 1'b0, "R6 restarted window", int'(busy), 0);
      t = LW - 8;
      while (!busy && t < LW + 20) begin @(negedge clk); t++; end
      chk(busy === 1'b1 && t >= LW - 2 && t <= LW + 4, "R6 start time", t, LW + 1);
      while (busy) @(negedge clk);
      apply_pend();
      rd_ref(9, 0, "R6 data 0");
      rd_ref(9, 1, "R6 data 1");
    end

    // R8 and R10 during programming
    ld(10, 4, 8'h80);
    while (!busy) @(negedge clk);
    wr(10 * 64 + 4, 8'h00);
    wr(11 * 64, 8'h77);
    rd(10 * 64 + 4, 8'h40, "R10 status first");
    rd(10 * 64 + 4, 8'h00, "R10 status second");
    chk(busy === 1'b1, "R10 reads inside busy", int'(busy), 1);
    while (busy) @(negedge clk);
    apply_pend();
    repeat (LW + 10) @(negedge clk);
    chk(busy === 1'b0, "R8 no new load", int'(busy), 0);
    rd(10 * 64 + 4, 8'h80, "R8 R7 true data after busy");
    rd(11 * 64, 8'h02, "R8 dropped write");

    // R2 capture points: WE falls first, CE later; addr and data move
    @(negedge clk); addr_p = AW'(12 * 64 + 20); we_n = 1'b0;
    @(negedge clk); addr_p = AW'(12 * 64 + 7); ce_n = 1'b0; din_p = 8'h10;
    @(negedge clk); addr_p = AW'(12 * 64 + 8); din_p = 8'h3C;
    @(negedge clk); ce_n = 1'b1; din_p = 8'hFF;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
    pp = 12; pd[7] = 8'h3C; pm[7] = 1'b1;
    commit("capture");
    rd(12 * 64 + 7, 8'h3C, "R2 latched address");
    rd(12 * 64 + 8, 8'h04, "R2 later address ignored");
    rd(12 * 64 + 20, int'(ref_mem[12 * 64 + 20]) & 8'hFF, "R2 earlier address ignored");

    @(negedge clk);
    chk(dout_oe === 1'b0, "R9 released", int'(dout_oe), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule